// File: doc/BRIEF.md
# Critical-Mode PFC Gate Sequencer

This block produces the gate pulse for a boost power-factor stage that runs in critical conduction. It takes four comparator results that are already digitized: the zero-current sense level, the end-of-on-time signal from the ramp compare, the peak-current trip, and a low-level comparator that signals when the zero-current pin is pulled down. It also takes an enable line from the fault supervisor. A new switching cycle starts on a falling edge of the zero-current level, once the current in the inductor has reached zero.

After each turn-off, zero-current edges are not accepted until a minimum off interval has passed. This caps the switching frequency. If no edge is accepted before the restart interval ends, a pulse is forced. Each pulse ends on the first of three events: the on-time comparator, the maximum on-time, or the peak-current trip. The peak-current trip is ignored during a blanking window at the start of the pulse. A debounced pull-low on the sense pin stops switching for as long as the pin is held low.

All intervals are parameters in clock ticks. Every comparator input passes through a synchronizer of `SYNC_STAGES` flops before the sequencer uses it. A status word reports the sequencer state, why the last pulse ended, whether the last turn-on was forced, and whether the disable is active.

Top module: `pfc_gate_seq`

## Requirements
- R1: A falling edge on `zcd_i` that is accepted turns `gate_o` on `SYNC_STAGES`+1 clock cycles after the edge reaches the pin. Such a turn-on clears status bit 4.
- R2: A falling edge on `zcd_i` applied j cycles after `gate_o` falls is accepted when j+`SYNC_STAGES`+1 >= `INHIB_TICKS`. The gate then stays low for j+`SYNC_STAGES`+1 cycles. An earlier edge is ignored, so the gate low time is never shorter than `INHIB_TICKS` cycles.
- R3: If no edge is accepted, `gate_o` stays low for exactly `RESTART_TICKS` cycles after it falls and then rises. Such a forced turn-on sets status bit 4.
- R4: With no other ending event, a pulse lasts exactly `TON_MAX_TICKS` cycles.
- R5: Assertion of `ton_end_i` ends the pulse `SYNC_STAGES`+1 cycles after it reaches the pin.
- R6: Assertion of `ilim_i` ends the pulse `SYNC_STAGES`+1 cycles after it reaches the pin, but never earlier than `BLANK_TICKS` cycles into the pulse. If `ilim_i` is held high from before turn-on, the pulse lasts exactly `BLANK_TICKS` cycles. A trip that falls entirely inside the blanking window has no effect.
- R7: Status bits [3:2] hold the cause of the last pulse end: 0 none, 1 on-time comparator, 2 maximum on-time, 3 current limit. When several causes arrive in the same cycle, current limit wins over maximum on-time, and maximum on-time wins over the on-time comparator.
- R8: If `zcd_dis_i` is held high for `DIS_DEB_TICKS` consecutive synchronized samples, `gate_o` goes low `SYNC_STAGES`+`DIS_DEB_TICKS`+1 cycles after it was applied. Status [1:0] then reads 3 and bit 5 reads 1, and the gate stays low while `zcd_dis_i` is held. A shorter low on the pin has no effect. After release, the gate rises `SYNC_STAGES`+2+`RESTART_TICKS` cycles later.
- R9: With `enable_i` low, `gate_o` falls `SYNC_STAGES`+1 cycles after the change, status [1:0] reads 0, and all timers are cleared. After `enable_i` returns high, the first pulse rises `SYNC_STAGES`+1+`RESTART_TICKS` cycles later.
- R10: While reset is applied, `gate_o` is 0 and `status_o` is 0. Status [1:0] encodes the state: 0 idle, 1 off, 2 on, 3 disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run permission from the fault supervisor |
| zcd_i | input | 1 | Zero-current comparator level; a falling edge marks zero current |
| ton_end_i | input | 1 | On-time comparator from the ramp compare |
| ilim_i | input | 1 | Peak-current comparator |
| zcd_dis_i | input | 1 | Comparator that signals the zero-current pin is pulled low |
| gate_o | output | 1 | Gate command |
| status_o | output | 6 | {disable active, forced turn-on, end cause[1:0], state[1:0]} |

## Verification
The assertions check on every cycle the rules that tie one cycle's internal state to the next gate value:
- no turn-on inside the inhibit window;
- turn-on when an accepted edge arrives or the restart count runs out;
- a forced end at the maximum on-time;
- no current-limit end inside the blanking window;
- the gate held low while disabled or not enabled.

Only the bench scenarios can show the exact port-to-port latencies through the synchronizers. The same holds for the inhibit acceptance boundary measured from the gate edge, the length of the disable debounce, the cause priority, and the recovery timing after disable or enable changes.

// File: rtl/pfc_seq_pkg.sv
`timescale 1ns/1ps
package pfc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OFF  = 2'd1,
    ST_ON   = 2'd2,
    ST_DIS  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    END_NONE = 2'd0,
    END_TON  = 2'd1,
    END_MAX  = 2'd2,
    END_ILIM = 2'd3
  } end_cause_t;

  localparam int IN_W    = 5;
  localparam int IX_DIS  = 0;
  localparam int IX_ILIM = 1;
  localparam int IX_TON  = 2;
  localparam int IX_ZCD  = 3;
  localparam int IX_EN   = 4;
endpackage

// File: rtl/pfc_in_sync.sv
`timescale 1ns/1ps
module pfc_in_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_stg[g-1].q;
      end
    end
  end

  assign dout = g_stg[STAGES-1].q;
endmodule

// File: rtl/pfc_dis_debounce.sv
`timescale 1ns/1ps
module pfc_dis_debounce #(
  parameter int DEB_TICKS = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_s,
  output logic active
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = !dis_s || (cnt_q != LIM);

  always_comb begin
    if (!dis_s) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q == LIM);

  // R8: a released pin drops the debounced disable on the next cycle
  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_s |=> !active);
  // R8: the debounced disable holds while the pin stays low
  a_r8_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dis_s) |=> active);
endmodule

// File: rtl/pfc_seq_timers.sv
`timescale 1ns/1ps
module pfc_seq_timers #(
  parameter int TON_MAX_TICKS = 5000,
  parameter int RESTART_TICKS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_on,
  input  logic run_off,
  output logic [$clog2(TON_MAX_TICKS+1)-1:0] on_cnt,
  output logic [$clog2(RESTART_TICKS+1)-1:0] off_cnt
);
  localparam int ON_W  = $clog2(TON_MAX_TICKS + 1);
  localparam int OFF_W = $clog2(RESTART_TICKS + 1);
  localparam logic [ON_W-1:0]  ON_SAT  = ON_W'(TON_MAX_TICKS - 1);
  localparam logic [OFF_W-1:0] OFF_SAT = OFF_W'(RESTART_TICKS - 1);

  logic [ON_W-1:0]  on_d;
  logic [OFF_W-1:0] off_d;
  logic             on_en, off_en;

  assign on_en  = !run_on  || (on_cnt  != ON_SAT);
  assign off_en = !run_off || (off_cnt != OFF_SAT);

  always_comb begin
    on_d  = run_on  ? on_cnt  + 1'b1 : '0;
    off_d = run_off ? off_cnt + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     on_cnt <= '0;
    else if (on_en) on_cnt <= on_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_cnt <= '0;
    else if (off_en) off_cnt <= off_d;
  end

  // R4: on counter never passes its saturation point
  a_r4_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (on_cnt == ON_SAT) |=> (on_cnt == ON_SAT || on_cnt == '0));
  // R3: off counter restarts from zero after an idle phase
  a_r3_off_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run_off |=> (off_cnt == '0));
endmodule

// File: rtl/pfc_gate_seq.sv
`timescale 1ns/1ps
module pfc_gate_seq
  import pfc_seq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int INHIB_TICKS   = 500,
  parameter int RESTART_TICKS = 100000,
  parameter int TON_MAX_TICKS = 5000,
  parameter int BLANK_TICKS   = 36,
  parameter int DIS_DEB_TICKS = 30000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       zcd_i,
  input  logic       ton_end_i,
  input  logic       ilim_i,
  input  logic       zcd_dis_i,
  output logic       gate_o,
  output logic [5:0] status_o
);
  localparam int ON_W  = $clog2(TON_MAX_TICKS + 1);
  localparam int OFF_W = $clog2(RESTART_TICKS + 1);
  localparam logic [OFF_W-1:0] INHIB_LIM   = OFF_W'(INHIB_TICKS - 1);
  localparam logic [OFF_W-1:0] RESTART_LIM = OFF_W'(RESTART_TICKS - 1);
  localparam logic [ON_W-1:0]  TON_LIM     = ON_W'(TON_MAX_TICKS - 1);
  localparam logic [ON_W-1:0]  BLANK_LIM   = ON_W'(BLANK_TICKS - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  // input synchronization
  logic [IN_W-1:0] raw, syn;
  assign raw[IX_DIS]  = zcd_dis_i;
  assign raw[IX_ILIM] = ilim_i;
  assign raw[IX_TON]  = ton_end_i;
  assign raw[IX_ZCD]  = zcd_i;
  assign raw[IX_EN]   = enable_i;

  pfc_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .din(raw), .dout(syn)
  );

  logic s_en, s_zcd, s_ton, s_ilim, s_dis;
  assign s_en   = syn[IX_EN];
  assign s_zcd  = syn[IX_ZCD];
  assign s_ton  = syn[IX_TON];
  assign s_ilim = syn[IX_ILIM];
  assign s_dis  = syn[IX_DIS];

  // falling-edge detect on the zero-current level
  logic zcd_prev, zcd_fall;
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) zcd_prev <= 1'b0;
    else         zcd_prev <= s_zcd;
  end
  assign zcd_fall = zcd_prev && !s_zcd;

  // disable debounce
  logic dis_act;
  pfc_dis_debounce #(.DEB_TICKS(DIS_DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_ns), .dis_s(s_dis), .active(dis_act)
  );

  // sequencer state
  seq_state_t state_q, state_d;
  end_cause_t cause_q, cause_d;
  logic       forced_q, forced_d;
  logic       gate_q;

  logic [ON_W-1:0]  on_cnt;
  logic [OFF_W-1:0] off_cnt;

  pfc_seq_timers #(.TON_MAX_TICKS(TON_MAX_TICKS), .RESTART_TICKS(RESTART_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_ns),
    .run_on(state_q == ST_ON), .run_off(state_q == ST_OFF),
    .on_cnt(on_cnt), .off_cnt(off_cnt)
  );

  logic zcd_ok, restart_due, ilim_ok, max_due;
  assign zcd_ok      = zcd_fall && (off_cnt >= INHIB_LIM);
  assign restart_due = (off_cnt == RESTART_LIM);
  assign ilim_ok     = s_ilim && (on_cnt >= BLANK_LIM);
  assign max_due     = (on_cnt == TON_LIM);

  always_comb begin
    state_d  = state_q;
    cause_d  = cause_q;
    forced_d = forced_q;
    if (!s_en) begin
      state_d = ST_IDLE;
    end else if (dis_act) begin
      state_d = ST_DIS;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DIS: state_d = ST_OFF;
        ST_OFF: begin
          if (zcd_ok || restart_due) begin
            state_d  = ST_ON;
            forced_d = !zcd_ok;
          end
        end
        ST_ON: begin
          if (ilim_ok) begin
            state_d = ST_OFF;
            cause_d = END_ILIM;
          end else if (max_due) begin
            state_d = ST_OFF;
            cause_d = END_MAX;
          end else if (s_ton) begin
            state_d = ST_OFF;
            cause_d = END_TON;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= ST_IDLE;
      cause_q  <= END_NONE;
      forced_q <= 1'b0;
      gate_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cause_q  <= cause_d;
      forced_q <= forced_d;
      gate_q   <= (state_d == ST_ON);
    end
  end

  assign gate_o   = gate_q;
  assign status_o = {dis_act, forced_q, cause_q, state_q};

  // R1: an accepted edge in the off state turns the gate on next cycle
  a_r1_zcd_on: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_OFF && s_en && !dis_act && zcd_ok) |=> gate_q);
  // R2: no turn-on inside the inhibit window
  a_r2_inhibit: assert property (@(posedge clk) disable iff (!rst_ns)
    (!gate_q && off_cnt < INHIB_LIM) |=> !gate_q);
  // R3: restart count exhausted forces a pulse
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_OFF && s_en && !dis_act && restart_due) |=> gate_q);
  // R4: maximum on-time ends the pulse
  a_r4_max_on: assert property (@(posedge clk) disable iff (!rst_ns)
    (gate_q && max_due) |=> !gate_q);
  // R6: current limit cannot end the pulse inside the blanking window
  a_r6_blank: assert property (@(posedge clk) disable iff (!rst_ns)
    (gate_q && s_en && !dis_act && !s_ton && on_cnt < BLANK_LIM) |=> gate_q);
  // R8: debounced disable holds the gate low
  a_r8_dis_off: assert property (@(posedge clk) disable iff (!rst_ns)
    dis_act |=> (!gate_q && state_q == ST_DIS));
  // R9: missing enable drops the gate and parks the sequencer
  a_r9_en_off: assert property (@(posedge clk) disable iff (!rst_ns)
    !s_en |=> (!gate_q && state_q == ST_IDLE));
  // R9: timers stay cleared while idle
  a_r9_timers_clear: assert property (@(posedge clk) disable iff (!rst_ns)
    (!s_en && state_q == ST_IDLE) |=> (on_cnt == '0 && off_cnt == '0));
endmodule

// File: tb/pfc_gate_seq_test.sv
`timescale 1ns/1ps
module pfc_gate_seq_test;
  localparam int S   = 2;
  localparam int INH = 8;
  localparam int RST = 40;
  localparam int TMX = 20;
  localparam int BLK = 5;
  localparam int DEB = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable_i, zcd_i, ton_end_i, ilim_i, zcd_dis_i;
  logic       gate_o;
  logic [5:0] status_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pfc_gate_seq #(
    .SYNC_STAGES(S), .INHIB_TICKS(INH), .RESTART_TICKS(RST),
    .TON_MAX_TICKS(TMX), .BLANK_TICKS(BLK), .DIS_DEB_TICKS(DEB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .zcd_i(zcd_i),
    .ton_end_i(ton_end_i), .ilim_i(ilim_i), .zcd_dis_i(zcd_dis_i),
    .gate_o(gate_o), .status_o(status_o)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int exp_width(int k, bit ui, int m);
    int w;
    w = min2(k + S + 1, TMX);
    if (ui) w = min2(w, (m + S + 1 > BLK) ? m + S + 1 : BLK);
    return w;
  endfunction

  function automatic int exp_cause(int k, bit ui, int m);
    int w, wi;
    w  = exp_width(k, ui, m);
    wi = (m + S + 1 > BLK) ? m + S + 1 : BLK;
    if (ui && wi == w) return 3;
    if (w == TMX) return 2;
    return 1;
  endfunction

  function automatic int exp_off(int j);
    return (j + S + 1 >= INH) ? j + S + 1 : RST;
  endfunction

  task automatic wait_high(output int n);
    n = 0;
    while (!gate_o && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_low(output int n);
    n = 0;
    while (gate_o && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  // called at the negedge where the gate is first seen high
  task automatic run_pulse(int k, bit ui, int m, output int w);
    w = 0;
    while (w < 200) begin
      if (w == k) ton_end_i = 1'b1;
      if (ui && w == m) ilim_i = 1'b1;
      @(negedge clk);
      w++;
      if (!gate_o) break;
    end
    ton_end_i = 1'b0;
    ilim_i    = 1'b0;
  endtask

  // called at the negedge where the gate is first seen low
  task automatic run_off(int j, output int l);
    l = 0;
    while (l < 200) begin
      if (l == j) zcd_i = 1'b0;
      @(negedge clk);
      l++;
      if (gate_o) break;
    end
    zcd_i = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int c, w, l, w2;
    int unsigned seed;
    seed = $urandom(32'd20417);
    rst_n = 1'b0; enable_i = 1'b0; zcd_i = 1'b1;
    ton_end_i = 1'b0; ilim_i = 1'b0; zcd_dis_i = 1'b0;
    repeat (4) @(negedge clk);
    check(gate_o == 1'b0, "R10 gate in reset", int'(gate_o), 0);
    check(status_o == 6'd0, "R10 status in reset", int'(status_o), 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check(gate_o == 1'b0, "R9 gate idle without enable", int'(gate_o), 0);
    check(status_o[1:0] == 2'd0, "R9 idle state code", int'(status_o[1:0]), 0);

    // R9: first pulse after enable
    enable_i = 1'b1;
    wait_high(c);
    check(c == S + 1 + RST, "R9 first rise after enable", c, S + 1 + RST);

    // R4 / R3: free-running restart pulses
    run_pulse(1000, 1'b0, 0, w);
    check(w == TMX, "R4 max on-time width", w, TMX);
    check(status_o[3:2] == 2'd2, "R7 cause max", int'(status_o[3:2]), 2);
    run_off(1000, l);
    check(l == RST, "R3 restart low time", l, RST);
    check(status_o[4] == 1'b1, "R3 forced flag", int'(status_o[4]), 1);

    // R5 and the R2 acceptance boundary
    run_pulse(4, 1'b0, 0, w);
    check(w == 4 + S + 1, "R5 on-time end width", w, 4 + S + 1);
    check(status_o[3:2] == 2'd1, "R7 cause on-time", int'(status_o[3:2]), 1);
    run_off(INH - S - 1, l);
    check(l == INH, "R2 earliest accepted edge", l, INH);
    check(status_o[4] == 1'b0, "R1 zcd turn-on clears forced", int'(status_o[4]), 0);

    // R6: trip confined to blanking is ignored
    ilim_i = 1'b1;
    @(negedge clk);
    ilim_i = 1'b0;
    run_pulse(1000, 1'b0, 0, w2);
    check(1 + w2 == TMX, "R6 blanked trip ignored", 1 + w2, TMX);
    ilim_i = 1'b1;
    run_off(INH - S - 2, l);
    check(l == RST, "R2 edge inside inhibit ignored", l, RST);

    // R6: trip held from before turn-on
    run_pulse(1000, 1'b0, 0, w);
    check(w == BLK, "R6 held trip width", w, BLK);
    check(status_o[3:2] == 2'd3, "R7 cause current limit", int'(status_o[3:2]), 3);
    run_off(INH - S, l);
    check(l == INH + 1, "R1 accepted edge latency", l, INH + 1);

    // R8: short pull-low has no effect
    zcd_dis_i = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    zcd_dis_i = 1'b0;
    run_pulse(1000, 1'b0, 0, w2);
    check(DEB - 1 + w2 == TMX, "R8 short disable ignored", DEB - 1 + w2, TMX);
    run_off(INH - S - 1, l);
    check(l == INH, "R2 boundary repeat", l, INH);

    // R8: debounced disable
    zcd_dis_i = 1'b1;
    wait_low(c);
    check(c == S + DEB + 1, "R8 disable latency", c, S + DEB + 1);
    @(negedge clk);
    check(status_o[1:0] == 2'd3, "R8 disabled state code", int'(status_o[1:0]), 3);
    check(status_o[5] == 1'b1, "R8 disable flag", int'(status_o[5]), 1);
    w = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (gate_o) w++;
    end
    check(w == 0, "R8 gate held low", w, 0);
    zcd_dis_i = 1'b0;
    wait_high(c);
    check(c == S + 2 + RST, "R8 recovery rise", c, S + 2 + RST);

    // constrained random pulses
    for (int it = 0; it < 40; it++) begin
      int k, m, j;
      bit ui;
      k  = int'($urandom_range(0, TMX + 3));
      m  = int'($urandom_range(0, 8));
      ui = 1'($urandom_range(0, 1));
      j  = int'($urandom_range(0, INH + 3));
      run_pulse(k, ui, m, w);
      check(w == exp_width(k, ui, m), "R5 R6 R4 random width", w, exp_width(k, ui, m));
      check(int'(status_o[3:2]) == exp_cause(k, ui, m), "R7 random cause",
            int'(status_o[3:2]), exp_cause(k, ui, m));
      run_off(j, l);
      check(l == exp_off(j), "R1 R2 R3 random off time", l, exp_off(j));
    end

    // R9: enable removed mid-pulse
    @(negedge clk);
    @(negedge clk);
    enable_i = 1'b0;
    wait_low(c);
    check(c == S + 1, "R9 gate drop on disable of enable", c, S + 1);
    @(negedge clk);
    check(status_o[1:0] == 2'd0, "R9 idle after enable low", int'(status_o[1:0]), 0);

    summary();
    $finish;
  end
endmodule